// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits behind a CAN receiver and chooses the message slot that a freshly decoded frame belongs to. The receiver presents the identifier, the extended-format flag, the remote-request flag, the length code and the first two payload bytes for one clock with a valid strobe. The filter holds fifteen slots. Each slot has an identifier, a standard or extended format bit, a direction (slots 1 to 14 only), and three enables that choose whether the global identifier mask and each of the two payload-byte masks apply to it.

Every slot is compared in parallel. The lowest-numbered slot that matches wins, and one clock after the valid strobe the block reports a hit flag, the slot number and a store strobe. Slot 15 always receives, and the frames it wins are queued in a two-entry FIFO that downstream logic drains with a pop input. A frame that finds the FIFO full is dropped, and an overrun pulse is raised in its place.

Top module: `can_accept_filter`

## Requirements
- R1: Without masking, a slot matches only when the frame's extended flag equals the slot's format bit and the identifier is equal: bits 10:0 for a standard slot, bits 28:0 for an extended slot.
- R2: When a slot's identifier-mask enable is set, only identifier bits whose global mask bit is 1 are compared, and mask bits of 0 are don't-care. When the enable is clear, the comparison is exact.
- R3: When a slot's first media enable is set, the slot matches only if the frame is not a remote request, its length code is at least 1, and ((byte0 XOR value0) AND mask0) is zero. When the enable is clear, byte 0 is ignored.
- R4: When a slot's second media enable is set, the slot matches only if the frame is not a remote request, its length code is at least 2, and ((byte1 XOR value1) AND mask1) is zero. When the enable is clear, byte 1 is ignored.
- R5: A slot from 1 to 14 whose direction bit is 0 (transmit) never matches. Slot 15 has no direction bit and always receives.
- R6: When several slots match, `slot_o` reports the lowest-numbered one, and a frame produces at most one single-cycle store strobe.
- R7: `hit_o`, `slot_o`, `store_o` and `ovr_o` are registered and reflect the frame presented in the previous cycle. They are 0 in any cycle that does not follow a valid strobe, and `slot_o` is 0 whenever `hit_o` is 0.
- R8: Frames won by slot 15 enter a FIFO in arrival order. `fifo_vld_o` is high while it is non-empty, the head fields show the oldest frame, and a pop advances the FIFO.
- R9: If slot 15 wins while the FIFO already holds two entries and no pop is requested, the frame is dropped. That cycle shows `hit_o`=1, `slot_o`=15, `store_o`=0 and `ovr_o`=1, and the stored contents are unchanged.
- R10: If slot 15 wins in the same cycle as a pop of a full FIFO, the frame is stored (`store_o`=1, `ovr_o`=0) behind the remaining entry.
- R11: During and after reset all decision outputs are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_id_i | input | 15*29 | Slot identifiers, slot n in bits [(n-1)*29 +: 29] |
| slot_ext_i | input | 15 | Slot format, 1 = extended, bit n-1 for slot n |
| slot_dir_rx_i | input | 14 | Direction of slots 1..14, 1 = receive |
| slot_idm_en_i | input | 15 | Per-slot global identifier mask enable |
| slot_m0_en_i | input | 15 | Per-slot payload byte 0 mask enable |
| slot_m1_en_i | input | 15 | Per-slot payload byte 1 mask enable |
| gid_mask_i | input | 29 | Global identifier mask, 1 = compare |
| med0_mask_i | input | 8 | Byte 0 mask, 1 = compare |
| med0_val_i | input | 8 | Byte 0 expected value |
| med1_mask_i | input | 8 | Byte 1 mask, 1 = compare |
| med1_val_i | input | 8 | Byte 1 expected value |
| frm_valid_i | input | 1 | Decoded frame present this cycle |
| frm_id_i | input | 29 | Frame identifier, standard in bits 10:0 |
| frm_ide_i | input | 1 | Frame is extended format |
| frm_rtr_i | input | 1 | Frame is a remote request |
| frm_dlc_i | input | 4 | Frame length code |
| frm_d0_i | input | 8 | Payload byte 0 |
| frm_d1_i | input | 8 | Payload byte 1 |
| hit_o | output | 1 | Some slot accepted the previous frame |
| slot_o | output | 4 | Winning slot number 1..15, 0 on no hit |
| store_o | output | 1 | Frame stored in the winning slot |
| ovr_o | output | 1 | Slot 15 frame dropped, FIFO full |
| fifo_pop_i | input | 1 | Remove the FIFO head |
| fifo_vld_o | output | 1 | FIFO holds at least one frame |
| fifo_id_o | output | 29 | Head frame identifier |
| fifo_ide_o | output | 1 | Head frame extended flag |
| fifo_dlc_o | output | 4 | Head frame length code |
| fifo_d0_o | output | 8 | Head frame byte 0 |
| fifo_d1_o | output | 8 | Head frame byte 1 |

## Verification
The two functions that can land in the same cycle are a slot-15 push from the acceptance decision and a pop from the downstream reader. The bench fills the FIFO with two frames and then presents a third slot-15 frame in the same cycle as a pop. It expects the frame to be stored without an overrun, and expects the drained order to be the second frame followed by the new one. The same full FIFO without a pop must instead give an overrun, a suppressed store and unchanged contents, so the two outcomes are judged against each other.

// File: rtl/can_acc_pkg.sv
`timescale 1ns/1ps
package can_acc_pkg;
  localparam int ID_W  = 29;
  localparam int SID_W = 11;
  localparam int DLC_W = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic [DLC_W-1:0]  dlc;
    logic [BYTE_W-1:0] d0;
    logic [BYTE_W-1:0] d1;
  } can_frm_t;
endpackage

// File: rtl/can_slot_match.sv
`timescale 1ns/1ps
module can_slot_match
  import can_acc_pkg::*;
(
  input  can_frm_t          frm_i,
  input  logic              rtr_i,
  input  logic [ID_W-1:0]   slot_id_i,
  input  logic              slot_ext_i,
  input  logic              slot_rx_i,
  input  logic              idm_en_i,
  input  logic              m0_en_i,
  input  logic              m1_en_i,
  input  logic [ID_W-1:0]   gid_mask_i,
  input  logic [BYTE_W-1:0] med0_mask_i,
  input  logic [BYTE_W-1:0] med0_val_i,
  input  logic [BYTE_W-1:0] med1_mask_i,
  input  logic [BYTE_W-1:0] med1_val_i,
  output logic              match_o
);
  localparam logic [ID_W-1:0] STD_FIELD = ID_W'((1 << SID_W) - 1);

  logic [ID_W-1:0] id_care;
  logic            fmt_ok, id_ok, m0_ok, m1_ok;

  always_comb begin
    id_care = idm_en_i ? gid_mask_i : '1;
    if (!slot_ext_i) id_care = id_care & STD_FIELD;
    fmt_ok = (frm_i.ide == slot_ext_i);
    id_ok  = (((frm_i.id ^ slot_id_i) & id_care) == '0);
    // a byte that the frame does not carry can never satisfy an enabled mask
    m0_ok  = !m0_en_i ||
             (!rtr_i && (frm_i.dlc >= DLC_W'(1)) &&
              (((frm_i.d0 ^ med0_val_i) & med0_mask_i) == '0));
    m1_ok  = !m1_en_i ||
             (!rtr_i && (frm_i.dlc >= DLC_W'(2)) &&
              (((frm_i.d1 ^ med1_val_i) & med1_mask_i) == '0));
    match_o = slot_rx_i && fmt_ok && id_ok && m0_ok && m1_ok;
  end
endmodule

// File: rtl/can_prio_pick.sv
`timescale 1ns/1ps
module can_prio_pick #(
  parameter int N    = 15,
  parameter int IDXW = $clog2(N + 1)
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    // scan downwards so the lowest requester is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i + 1);
    end
  end
endmodule

// File: rtl/can_rx_fifo.sv
`timescale 1ns/1ps
module can_rx_fifo
  import can_acc_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push_i,
  input  can_frm_t din_i,
  input  logic     pop_i,
  output logic     vld_o,
  output logic     full_o,
  output can_frm_t dout_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  can_frm_t        mem [DEPTH];
  logic [PW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            do_pop, do_push;

  always_comb begin
    do_pop  = pop_i && (cnt_q != '0);
    do_push = push_i;
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + PW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  assign vld_o  = (cnt_q != '0);
  assign full_o = (cnt_q == CW'(DEPTH));
  assign dout_o = mem[rd_q];
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter
  import can_acc_pkg::*;
#(
  parameter int NSLOT      = 15,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOT*ID_W-1:0] slot_id_i,
  input  logic [NSLOT-1:0]      slot_ext_i,
  input  logic [NSLOT-2:0]      slot_dir_rx_i,
  input  logic [NSLOT-1:0]      slot_idm_en_i,
  input  logic [NSLOT-1:0]      slot_m0_en_i,
  input  logic [NSLOT-1:0]      slot_m1_en_i,
  input  logic [ID_W-1:0]       gid_mask_i,
  input  logic [BYTE_W-1:0]     med0_mask_i,
  input  logic [BYTE_W-1:0]     med0_val_i,
  input  logic [BYTE_W-1:0]     med1_mask_i,
  input  logic [BYTE_W-1:0]     med1_val_i,
  input  logic                  frm_valid_i,
  input  logic [ID_W-1:0]       frm_id_i,
  input  logic                  frm_ide_i,
  input  logic                  frm_rtr_i,
  input  logic [DLC_W-1:0]      frm_dlc_i,
  input  logic [BYTE_W-1:0]     frm_d0_i,
  input  logic [BYTE_W-1:0]     frm_d1_i,
  output logic                  hit_o,
  output logic [$clog2(NSLOT+1)-1:0] slot_o,
  output logic                  store_o,
  output logic                  ovr_o,
  input  logic                  fifo_pop_i,
  output logic                  fifo_vld_o,
  output logic [ID_W-1:0]       fifo_id_o,
  output logic                  fifo_ide_o,
  output logic [DLC_W-1:0]      fifo_dlc_o,
  output logic [BYTE_W-1:0]     fifo_d0_o,
  output logic [BYTE_W-1:0]     fifo_d1_o
);
  localparam int IDXW = $clog2(NSLOT + 1);
  localparam logic [IDXW-1:0] FIFO_SLOT = IDXW'(NSLOT);

  can_frm_t          frm;
  can_frm_t          head;
  logic [NSLOT-1:0]  rx_vec;
  logic [NSLOT-1:0]  match;
  logic              any_match;
  logic [IDXW-1:0]   win_idx;
  logic              fifo_win, fifo_room, fifo_full, fifo_push;

  logic              hit_d, hit_q, store_d, store_q, ovr_d, ovr_q;
  logic [IDXW-1:0]   slot_d, slot_q;

  assign frm    = '{id: frm_id_i, ide: frm_ide_i, dlc: frm_dlc_i,
                    d0: frm_d0_i, d1: frm_d1_i};
  // the last slot has no direction bit and always receives
  assign rx_vec = {1'b1, slot_dir_rx_i};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    can_slot_match u_match (
      .frm_i       (frm),
      .rtr_i       (frm_rtr_i),
      .slot_id_i   (slot_id_i[g*ID_W +: ID_W]),
      .slot_ext_i  (slot_ext_i[g]),
      .slot_rx_i   (rx_vec[g]),
      .idm_en_i    (slot_idm_en_i[g]),
      .m0_en_i     (slot_m0_en_i[g]),
      .m1_en_i     (slot_m1_en_i[g]),
      .gid_mask_i  (gid_mask_i),
      .med0_mask_i (med0_mask_i),
      .med0_val_i  (med0_val_i),
      .med1_mask_i (med1_mask_i),
      .med1_val_i  (med1_val_i),
      .match_o     (match[g])
    );
  end

  can_prio_pick #(.N(NSLOT), .IDXW(IDXW)) u_pick (
    .req_i (match),
    .any_o (any_match),
    .idx_o (win_idx)
  );

  always_comb begin
    fifo_win  = frm_valid_i && any_match && (win_idx == FIFO_SLOT);
    // a pop in the same cycle frees the entry the push needs
    fifo_room = !fifo_full || fifo_pop_i;
    fifo_push = fifo_win && fifo_room;
    hit_d     = frm_valid_i && any_match;
    slot_d    = hit_d ? win_idx : '0;
    ovr_d     = fifo_win && !fifo_room;
    store_d   = hit_d && !ovr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      slot_q  <= '0;
      store_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      slot_q  <= slot_d;
      store_q <= store_d;
      ovr_q   <= ovr_d;
    end
  end

  can_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (fifo_push),
    .din_i  (frm),
    .pop_i  (fifo_pop_i),
    .vld_o  (fifo_vld_o),
    .full_o (fifo_full),
    .dout_o (head)
  );

  assign hit_o      = hit_q;
  assign slot_o     = slot_q;
  assign store_o    = store_q;
  assign ovr_o      = ovr_q;
  assign fifo_id_o  = head.id;
  assign fifo_ide_o = head.ide;
  assign fifo_dlc_o = head.dlc;
  assign fifo_d0_o  = head.d0;
  assign fifo_d1_o  = head.d1;
endmodule

// File: rtl/can_accept_filter_chk.sv
`timescale 1ns/1ps
module can_accept_filter_chk #(
  parameter int NSLOT = 15,
  parameter int IDXW  = $clog2(NSLOT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_valid_i,
  input logic [NSLOT-2:0] slot_dir_rx_i,
  input logic             hit_o,
  input logic [IDXW-1:0]  slot_o,
  input logic             store_o,
  input logic             ovr_o,
  input logic             fifo_pop_i,
  input logic             fifo_vld_o
);
  logic [NSLOT-2:0] dir_q;
  logic             seen_q;
  logic [IDXW-1:0]  sidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      dir_q  <= slot_dir_rx_i;
      seen_q <= 1'b1;
    end
  end

  assign sidx = slot_o - IDXW'(1);

  // R7
  decision_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && hit_o) |-> $past(frm_valid_i));

  // R7
  idle_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (slot_o == '0));

  // R6
  store_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_o |-> hit_o);

  // R9
  overrun_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (hit_o && !store_o && (slot_o == IDXW'(NSLOT))));

  // R5
  tx_slot_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && hit_o && (slot_o != IDXW'(NSLOT))) |-> dir_q[sidx]);

  // R8
  fifo_drain_needs_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $fell(fifo_vld_o)) |-> $past(fifo_pop_i));
endmodule

bind can_accept_filter can_accept_filter_chk #(.NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frm_valid_i   (frm_valid_i),
  .slot_dir_rx_i (slot_dir_rx_i),
  .hit_o         (hit_o),
  .slot_o        (slot_o),
  .store_o       (store_o),
  .ovr_o         (ovr_o),
  .fifo_pop_i    (fifo_pop_i),
  .fifo_vld_o    (fifo_vld_o)
);

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb;
  localparam int NSLOT = 15;
  localparam int IDW   = 29;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSLOT*IDW-1:0] slot_id;
  logic [NSLOT-1:0] slot_ext, idm_en, m0_en, m1_en;
  logic [NSLOT-2:0] dir_rx;
  logic [IDW-1:0]   gmask;
  logic [7:0]       mk0, v0, mk1, v1;
  logic             fv, ide, rtr, pop;
  logic [IDW-1:0]   fid;
  logic [3:0]       dlc;
  logic [7:0]       d0, d1;
  logic             hit, store, ovr, fvld, fide;
  logic [3:0]       slot, fdlc;
  logic [IDW-1:0]   ffid;
  logic [7:0]       fd0, fd1;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  can_accept_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .slot_id_i(slot_id), .slot_ext_i(slot_ext), .slot_dir_rx_i(dir_rx),
    .slot_idm_en_i(idm_en), .slot_m0_en_i(m0_en), .slot_m1_en_i(m1_en),
    .gid_mask_i(gmask), .med0_mask_i(mk0), .med0_val_i(v0),
    .med1_mask_i(mk1), .med1_val_i(v1),
    .frm_valid_i(fv), .frm_id_i(fid), .frm_ide_i(ide), .frm_rtr_i(rtr),
    .frm_dlc_i(dlc), .frm_d0_i(d0), .frm_d1_i(d1),
    .hit_o(hit), .slot_o(slot), .store_o(store), .ovr_o(ovr),
    .fifo_pop_i(pop), .fifo_vld_o(fvld), .fifo_id_o(ffid), .fifo_ide_o(fide),
    .fifo_dlc_o(fdlc), .fifo_d0_o(fd0), .fifo_d1_o(fd1)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_dec(input string req, input logic h, input logic [3:0] s,
                            input logic st, input logic ov);
    chk(req, "hit", 32'(hit), 32'(h));
    chk(req, "slot", 32'(slot), 32'(s));
    chk(req, "store", 32'(store), 32'(st));
    chk(req, "ovr", 32'(ovr), 32'(ov));
  endtask

  // one-cycle frame; returns at the negedge where the decision is visible
  task automatic send(input logic [IDW-1:0] i, input logic e, input logic r,
                      input logic [3:0] l, input logic [7:0] a, input logic [7:0] b,
                      input logic p);
    @(negedge clk);
    fid = i; ide = e; rtr = r; dlc = l; d0 = a; d1 = b; fv = 1'b1; pop = p;
    @(negedge clk);
    fv = 1'b0; pop = 1'b0;
  endtask

  task automatic do_pop();
    @(negedge clk);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic clr_cfg();
    slot_id = '0; slot_ext = '0; dir_rx = '0;
    idm_en = '0; m0_en = '0; m1_en = '0;
    gmask = '0; mk0 = '0; v0 = '0; mk1 = '0; v1 = '0;
    // park slot 15 on an identifier no test frame uses
    slot_id[14*IDW +: IDW] = 29'h1FFFFFFF;
    slot_ext[14] = 1'b1;
  endtask

  task automatic set_slot(input int n, input logic [IDW-1:0] i, input logic e,
                          input logic rx, input logic im, input logic a,
                          input logic b);
    slot_id[(n-1)*IDW +: IDW] = i;
    slot_ext[n-1] = e;
    if (n < NSLOT) dir_rx[n-1] = rx;
    idm_en[n-1] = im; m0_en[n-1] = a; m1_en[n-1] = b;
  endtask

  task automatic t_reset();
    chk("R11", "hit", 32'(hit), 0);
    chk("R11", "slot", 32'(slot), 0);
    chk("R11", "store", 32'(store), 0);
    chk("R11", "ovr", 32'(ovr), 0);
    chk("R11", "fifo_vld", 32'(fvld), 0);
  endtask

  task automatic t_exact();
    clr_cfg();
    set_slot(3, 29'h123, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    set_slot(5, 29'h0ABCDEF0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send(29'h123, 0, 0, 8, 0, 0, 0);        expect_dec("R1", 1, 3, 1, 0);
    send(29'h124, 0, 0, 8, 0, 0, 0);        expect_dec("R1", 0, 0, 0, 0);
    send(29'h123, 1, 0, 8, 0, 0, 0);        expect_dec("R1", 0, 0, 0, 0);
    // upper bits are outside the standard field
    send(29'h1000123, 0, 0, 8, 0, 0, 0);    expect_dec("R1", 1, 3, 1, 0);
    send(29'h0ABCDEF0, 1, 0, 8, 0, 0, 0);   expect_dec("R1", 1, 5, 1, 0);
    send(29'h1ABCDEF0, 1, 0, 8, 0, 0, 0);   expect_dec("R1", 0, 0, 0, 0);
    send(29'h0ABCDEF0, 0, 0, 8, 0, 0, 0);   expect_dec("R1", 0, 0, 0, 0);
    // R7: one idle cycle after a decision returns to zero
    @(negedge clk);
    expect_dec("R7", 0, 0, 0, 0);
  endtask

  task automatic t_idmask();
    clr_cfg();
    gmask = 29'h1FFFFF0F;
    set_slot(4, 29'h0F0F0F05, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    send(29'h0F0F0FF5, 1, 0, 0, 0, 0, 0);   expect_dec("R2", 1, 4, 1, 0);
    send(29'h0F0F0F04, 1, 0, 0, 0, 0, 0);   expect_dec("R2", 0, 0, 0, 0);
    idm_en[3] = 1'b0;
    send(29'h0F0F0FF5, 1, 0, 0, 0, 0, 0);   expect_dec("R2", 0, 0, 0, 0);
  endtask

  // every combination of the three per-slot enables
  task automatic t_combos();
    logic e_h;
    clr_cfg();
    gmask = 29'h1FFFFFF0;
    mk0 = 8'hF0; v0 = 8'hA0; mk1 = 8'h0F; v1 = 8'h05;
    for (int c = 0; c < 8; c++) begin
      logic im, a, b;
      im = c[0]; a = c[1]; b = c[2];
      set_slot(2, 29'h155, 1'b0, 1'b1, im, a, b);
      send(29'h154, 0, 0, 8, 8'hA3, 8'h55, 0);
      e_h = im;
      expect_dec("R2", e_h, e_h ? 4'd2 : 4'd0, e_h, 0);
      send(29'h155, 0, 0, 8, 8'h23, 8'h55, 0);
      e_h = !a;
      expect_dec("R3", e_h, e_h ? 4'd2 : 4'd0, e_h, 0);
      send(29'h155, 0, 0, 8, 8'hA3, 8'h54, 0);
      e_h = !b;
      expect_dec("R4", e_h, e_h ? 4'd2 : 4'd0, e_h, 0);
      send(29'h155, 0, 0, 1, 8'hA3, 8'h55, 0);
      e_h = !b;
      expect_dec("R4", e_h, e_h ? 4'd2 : 4'd0, e_h, 0);
      send(29'h155, 0, 0, 0, 8'hA3, 8'h55, 0);
      e_h = !a && !b;
      expect_dec("R3", e_h, e_h ? 4'd2 : 4'd0, e_h, 0);
      send(29'h155, 0, 1, 8, 8'hA3, 8'h55, 0);
      e_h = !a && !b;
      expect_dec("R3", e_h, e_h ? 4'd2 : 4'd0, e_h, 0);
    end
  endtask

  task automatic t_dir();
    clr_cfg();
    set_slot(4, 29'h2AA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    set_slot(7, 29'h2AA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(29'h2AA, 0, 0, 2, 0, 0, 0);        expect_dec("R5", 1, 7, 1, 0);
    dir_rx[6] = 1'b0;
    send(29'h2AA, 0, 0, 2, 0, 0, 0);        expect_dec("R5", 0, 0, 0, 0);
  endtask

  task automatic t_prio();
    clr_cfg();
    set_slot(2, 29'h0AA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    set_slot(6, 29'h0AA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    set_slot(9, 29'h0AA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    set_slot(15, 29'h0AA, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(29'h0AA, 0, 0, 3, 0, 0, 0);        expect_dec("R6", 1, 2, 1, 0);
    chk("R6", "fifo_vld", 32'(fvld), 0);
    @(negedge clk);
    chk("R6", "store second cycle", 32'(store), 0);
    dir_rx[1] = 1'b0;
    send(29'h0AA, 0, 0, 3, 0, 0, 0);        expect_dec("R6", 1, 6, 1, 0);
  endtask

  task automatic t_fifo();
    clr_cfg();
    set_slot(15, 29'h321, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(29'h321, 0, 0, 5, 8'h01, 8'hE1, 0); expect_dec("R8", 1, 15, 1, 0);
    send(29'h321, 0, 0, 6, 8'h02, 8'hE2, 0); expect_dec("R8", 1, 15, 1, 0);
    chk("R8", "fifo_vld", 32'(fvld), 1);
    chk("R8", "head d0", 32'(fd0), 32'h01);
    chk("R8", "head id", 32'(ffid), 32'h321);
    chk("R8", "head dlc", 32'(fdlc), 5);
    chk("R8", "head ide", 32'(fide), 0);
    do_pop();
    chk("R8", "head d0", 32'(fd0), 32'h02);
    chk("R8", "head d1", 32'(fd1), 32'hE2);
    do_pop();
    chk("R8", "fifo_vld empty", 32'(fvld), 0);
  endtask

  task automatic t_ovr();
    clr_cfg();
    set_slot(15, 29'h321, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(29'h321, 0, 0, 2, 8'h11, 0, 0);
    send(29'h321, 0, 0, 2, 8'h22, 0, 0);
    send(29'h321, 0, 0, 2, 8'h33, 0, 0);     expect_dec("R9", 1, 15, 0, 1);
    @(negedge clk);
    chk("R9", "ovr pulse ends", 32'(ovr), 0);
    chk("R9", "head d0", 32'(fd0), 32'h11);
    do_pop();
    chk("R9", "head d0", 32'(fd0), 32'h22);
    do_pop();
    chk("R9", "fifo_vld empty", 32'(fvld), 0);
  endtask

  task automatic t_simul();
    clr_cfg();
    set_slot(15, 29'h321, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send(29'h321, 0, 0, 2, 8'h44, 0, 0);
    send(29'h321, 0, 0, 2, 8'h55, 0, 0);
    send(29'h321, 0, 0, 2, 8'h66, 0, 1);     expect_dec("R10", 1, 15, 1, 0);
    chk("R10", "head d0", 32'(fd0), 32'h55);
    do_pop();
    chk("R10", "head d0", 32'(fd0), 32'h66);
    do_pop();
    chk("R10", "fifo_vld empty", 32'(fvld), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R7 watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fv = 1'b0; pop = 1'b0; fid = '0; ide = 1'b0; rtr = 1'b0;
    dlc = '0; d0 = '0; d1 = '0;
    clr_cfg();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_idmask();
    t_combos();
    t_dir();
    t_prio();
    t_fifo();
    t_ovr();
    t_simul();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule